// File: doc/BRIEF.md
# Adder Condition Flag Generator

This block sits next to a two's-complement adder and produces the four condition flags: negative, zero, carry and overflow. It receives the two adder operands and the value on the result bus. From these it works out each flag using only the sign bits and a zero test. Carry is reconstructed from the operand and result signs, so no extra carry-out bit is taken from the adder.

The four flags live in a small registered bank. Each flag changes on a rising clock edge only when its own update request is raised. An add-type request rewrites all four flags. A logic-type request, used by bitwise AND and NOT results, rewrites only negative and zero, and leaves carry and overflow as they were.

The update requests are plain level controls with no handshake. A request is taken on every rising edge where it is high. The result bus must carry the value whose flags are wanted during that cycle.

Top module: `adder_flag_unit`

## Requirements
- R1: While rst_n is low, and after it rises with no update request, all four flags read 0.
- R2: On an edge with upd_arith or upd_logic high, flag_n becomes the top bit of sum_in (the result read as signed is negative).
- R3: On an edge with upd_arith or upd_logic high, flag_z becomes 1 exactly when every bit of sum_in is 0; flag_n and flag_z are never both 1.
- R4: On an add update where op_a and op_b have the same sign, flag_c becomes 1 if both are negative and 0 if both are non-negative.
- R5: On an add update where the operand signs differ, flag_c becomes 1 if sum_in is non-negative and 0 if it is negative.
- R6: On an add update where the operand signs differ, flag_v becomes 0.
- R7: On an add update where the operand signs match, flag_v becomes 1 exactly when the top bit of sum_in differs from that shared sign.
- R8: On an edge with upd_logic high and upd_arith low, flag_c and flag_v keep their previous values.
- R9: On an edge with both update requests low, all four flags keep their values.
- R10: When both requests are high on one edge, the add rules apply to all four flags.
- R11: When sum_in equals op_a + op_b modulo 2^WIDTH, flag_c equals the carry out of the unsigned (WIDTH+1)-bit sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the flag bank |
| op_a | input | WIDTH | First adder operand |
| op_b | input | WIDTH | Second adder operand |
| sum_in | input | WIDTH | Result bus: adder sum or logic result |
| upd_arith | input | 1 | Add-type update: write all four flags |
| upd_logic | input | 1 | Logic-type update: write negative and zero only |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The bench uses a 6-bit build and applies every operand pair twice. In the first pass the result bus holds the true sum, and carry and overflow are checked against the 7-bit unsigned sum and the signed range. A unit whose carry cases are swapped when the signs differ, or whose overflow test looks at the wrong operand, fails on many of these pairs. In the second pass the result bus holds unrelated values, so a design that quietly takes carry from a true adder bit is caught. Logic-only updates are applied on top of preset carry and overflow values to catch a bank that overwrites them, and idle and dual-request cycles expose wrong enable wiring.

// File: rtl/flag_pkg.sv
package flag_pkg;
  // Bit positions inside the packed flag vector.
  localparam int unsigned FLG_V = 0;
  localparam int unsigned FLG_C = 1;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_COUNT = 4;

  typedef logic [FLG_COUNT-1:0] flag_vec_t;

  // Which update class writes which flag: 1 = also written by logic updates.
  localparam flag_vec_t LOGIC_WRITES = flag_vec_t'((1 << FLG_N) | (1 << FLG_Z));
endpackage

// File: rtl/flag_eval.sv
module flag_eval
  import flag_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] res,
  output flag_vec_t        flags
);
  localparam int unsigned MSB = WIDTH - 1;

  logic sign_a, sign_b, sign_r, signs_differ;

  always_comb begin
    sign_a       = op_a[MSB];
    sign_b       = op_b[MSB];
    sign_r       = res[MSB];
    signs_differ = sign_a ^ sign_b;

    flags         = '0;
    flags[FLG_N]  = sign_r;
    flags[FLG_Z]  = ~|res;
    // Same signs: carry follows the shared sign. Differing: carry when result non-negative.
    flags[FLG_C]  = signs_differ ? ~sign_r : (sign_a & sign_b);
    // Overflow only possible with matching operand signs.
    flags[FLG_V]  = ~signs_differ & (sign_r ^ sign_a);
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd_arith,
  input  logic      upd_logic,
  input  flag_vec_t next_flags,
  output flag_vec_t cur_flags
);
  flag_vec_t wr_en;

  always_comb begin
    for (int i = 0; i < int'(FLG_COUNT); i++)
      wr_en[i] = upd_arith | (upd_logic & LOGIC_WRITES[i]);
  end

  for (genvar g = 0; g < int'(FLG_COUNT); g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        cur_flags[g] <= 1'b0;
      else if (wr_en[g]) cur_flags[g] <= next_flags[g];
    end
  end

  AST_NZ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur_flags[FLG_N] && cur_flags[FLG_Z])); // R3

  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_logic && !upd_arith) |=> $stable(cur_flags[FLG_C]) && $stable(cur_flags[FLG_V])); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_logic && !upd_arith) |=> $stable(cur_flags)); // R9
endmodule

// File: rtl/adder_flag_unit.sv
module adder_flag_unit
  import flag_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] sum_in,
  input  logic             upd_arith,
  input  logic             upd_logic,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int unsigned MSB = WIDTH - 1;

  flag_vec_t eval_flags, held_flags;

  flag_eval #(.WIDTH(WIDTH)) u_eval (
    .op_a  (op_a),
    .op_b  (op_b),
    .res   (sum_in),
    .flags (eval_flags)
  );

  flag_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_arith  (upd_arith),
    .upd_logic  (upd_logic),
    .next_flags (eval_flags),
    .cur_flags  (held_flags)
  );

  assign flag_n = held_flags[FLG_N];
  assign flag_z = held_flags[FLG_Z];
  assign flag_c = held_flags[FLG_C];
  assign flag_v = held_flags[FLG_V];

  AST_N_TRACKS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_arith || upd_logic) |=> flag_n == $past(sum_in[MSB])); // R2

  AST_C_BOTH_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_arith && op_a[MSB] && op_b[MSB]) |=> flag_c); // R4

  AST_C_BOTH_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_arith && !op_a[MSB] && !op_b[MSB]) |=> !flag_c); // R4

  AST_V_SIGNS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_arith && (op_a[MSB] != op_b[MSB])) |=> !flag_v); // R6
endmodule

// File: tb/sim_adder_flag_unit.sv
module sim_adder_flag_unit;
  localparam int W = 6;
  localparam int SPAN = 1 << W;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] op_a = '0, op_b = '0, sum_in = '0;
  logic upd_arith = 0, upd_logic = 0;
  logic flag_n, flag_z, flag_c, flag_v;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  adder_flag_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum_in(sum_in),
    .upd_arith(upd_arith), .upd_logic(upd_logic),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d s=%0d act=%0d exp=%0d", req, op_a, op_b, sum_in, act, exp);
    end
  endtask

  function automatic int sgn(int x);
    return (x >= SPAN/2) ? x - SPAN : x;
  endfunction

  // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
  task automatic apply(int a, int b, int s, bit ua, bit ul);
    @(negedge clk);
    op_a = W'(a); op_b = W'(b); sum_in = W'(s); upd_arith = ua; upd_logic = ul;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 n", int'(flag_n), 0); chk("R1 z", int'(flag_z), 0);
    chk("R1 c", int'(flag_c), 0); chk("R1 v", int'(flag_v), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'({flag_n, flag_z, flag_c, flag_v}), 0);

    // Pass 1: true sums, expectations from wide arithmetic.
    for (int a = 0; a < SPAN; a++)
      for (int b = 0; b < SPAN; b++) begin
        int full, ssum;
        full = a + b;
        ssum = sgn(a) + sgn(b);
        apply(a, b, full % SPAN, 1, 0);
        chk("R2", int'(flag_n), int'((full % SPAN) >= SPAN/2));
        chk("R3", int'(flag_z), int'((full % SPAN) == 0));
        chk("R11", int'(flag_c), int'(full >= SPAN));
        chk("R7 R6", int'(flag_v), int'(ssum < -SPAN/2 || ssum >= SPAN/2));
      end

    // Pass 2: arbitrary result bus values; carry and overflow from sign rules.
    for (int a = 0; a < SPAN; a++)
      for (int b = 0; b < SPAN; b++) begin
        int s, ec, ev;
        bit na, nb, ns;
        s = (a * 7 + b * 13 + 5) % SPAN;
        na = sgn(a) < 0; nb = sgn(b) < 0; ns = sgn(s) < 0;
        if (na == nb) begin ec = int'(na); ev = int'(ns != na); end
        else begin ec = int'(!ns); ev = 0; end
        apply(a, b, s, 1, 0);
        chk((na == nb) ? "R4" : "R5", int'(flag_c), ec);
        chk((na == nb) ? "R7" : "R6", int'(flag_v), ev);
        chk("R3 excl", int'(flag_n && flag_z), 0);
      end

    // Logic updates over preset carry/overflow states.
    for (int pre = 0; pre < 4; pre++)
      for (int r = 0; r < SPAN; r++) begin
        int pa, pb, ps, ec, ev;
        // pre 0: c0 v0 ; 1: c1 v0 ; 2: c0 v1 ; 3: c1 v1
        case (pre)
          0: begin pa = 1;          pb = 1;          ps = 2;          end
          1: begin pa = SPAN-1;     pb = 2;          ps = 1;          end
          2: begin pa = SPAN/2-1;   pb = 1;          ps = SPAN/2;     end
          default: begin pa = SPAN/2; pb = SPAN/2;   ps = 0;          end
        endcase
        ec = pre % 2; ev = pre / 2;
        apply(pa, pb, ps, 1, 0);
        apply((r * 5) % SPAN, (r * 11 + 3) % SPAN, r, 0, 1);
        chk("R8 c", int'(flag_c), ec);
        chk("R8 v", int'(flag_v), ev);
        chk("R2 logic", int'(flag_n), int'(r >= SPAN/2));
        chk("R3 logic", int'(flag_z), int'(r == 0));
      end

    // Idle hold.
    apply(SPAN/2, SPAN/2, 0, 1, 0);      // n0 z1 c1 v1
    apply(1, 2, SPAN - 1, 0, 0);
    chk("R9 idle", int'({flag_n, flag_z, flag_c, flag_v}), 'b0111);
    apply(SPAN - 1, 0, SPAN/2, 0, 0);
    chk("R9 idle2", int'({flag_n, flag_z, flag_c, flag_v}), 'b0111);

    // Both requests: all four follow add rules.
    apply(SPAN/2 - 1, 1, SPAN/2, 1, 0); // n1 z0 c0 v1
    apply(SPAN - 1, 1, 0, 1, 1);        // signs differ, result 0 -> n0 z1 c1 v0
    chk("R10", int'({flag_n, flag_z, flag_c, flag_v}), 'b0110);
    apply(1, 1, SPAN/2, 1, 1);          // both pos, sign flips -> n1 z0 c0 v1
    chk("R10 b", int'({flag_n, flag_z, flag_c, flag_v}), 'b1001);

    // Reset again clears.
    @(negedge clk); rst_n = 0; upd_arith = 0; upd_logic = 0;
    @(negedge clk);
    chk("R1 re-reset", int'({flag_n, flag_z, flag_c, flag_v}), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule